// File: doc/BRIEF.md
# Complementary-Output PWM Timer Channel

This block is a single PWM timer channel. An up-counter advances on ticks from a selectable prescaler. It restarts at zero after it reaches a programmable top value. A compare value splits each period into a high phase and a low phase of an output flip-flop. The flip-flop drives two pins: a true copy and an inverted copy. Each pin has its own enable. Software programs the channel through a small write-strobe bus with four addresses: top, compare, control and a force strobe.

The channel is built so that PWM can start without a runt pulse. In PWM mode a compare write is parked in a holding register. It only becomes active when the counter wraps, so a period is never cut short. Outside PWM mode a force strobe can preset the output flip-flop. The flip-flop keeps its value when the mode changes, so software can choose the first level before the counter starts. The recommended start sequence is:

1. Choose normal mode with the clock stopped.
2. Write top and compare.
3. Force the flip-flop high.
4. Write a single control word that selects PWM, selects the clock and enables the pins.

Every phase then lasts a whole number of prescaled ticks from the very first cycle.

Top module: `cpwm_channel`

## Requirements
- R1: The counter counts 0,1,…,top and then returns to 0, so a period is top+1 prescaled ticks. A write to the top address (0) stores the value and restarts both the counter and the prescaler at 0.
- R2: Control bits [2:0] select the clock. 0 stops the counter, which then holds its value. 1, 2, 3 and 4 divide the system clock by 1, 2, 4 and 8. Values 5 to 7 also divide by 8.
- R3: Control bit 5 selects PWM mode, and control bits [4:3] are the output mode. In PWM mode with output mode 01, the flip-flop is set when the counter wraps to 0 and cleared when the counter advances to the active compare value. The set wins, so a compare of 0 keeps the flip-flop high. In PWM mode with any other output mode, the flip-flop holds its value.
- R4: In PWM mode, a write to the compare address (1) goes to a holding register. It becomes active on the tick where the counter wraps from top to 0. The period in progress keeps the old compare value.
- R5: Outside PWM mode, a compare write becomes active on the next clock.
- R6: A write to the force address (3) with data bit 0 set acts only outside PWM mode. Output mode 10 clears the flip-flop, 11 sets it, and 00 and 01 leave it unchanged. In PWM mode the strobe has no effect.
- R7: The flip-flop keeps its value across mode changes and while the clock is stopped.
- R8: Control bit 6 enables the true pin, which then shows the flip-flop. Control bit 7 enables the inverted pin, which then shows the flip-flop's complement. A disabled pin drives 0.
- R9: After a preset-high start with top 35, compare 17 and divide-by-4, the true pin is high for 68 cycles and low for 76 cycles in every period, starting with the first. No phase on either pin is shorter than one tick.
- R10: After reset, all registers, the counter and the flip-flop are 0, the clock is stopped and both pins drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 top, 1 compare, 2 control, 3 force |
| wr_data | input | 8 | Write data |
| pin_true | output | 1 | Gated true waveform |
| pin_inv | output | 1 | Gated inverted waveform |

## Verification
The assertions take for granted that software writes at most one register per cycle. They also assume that a top value is never written below a count that is still in use; the top write resets the count, which keeps this safe. Finally, they assume that the prescaler tick and the counter are the only sources of PWM events.

The stimulus follows these assumptions. Each sweep point rebuilds the configuration from normal mode with the clock stopped, using separate single-cycle writes. Buffered compare writes are issued only while the count is known, right after an observed rising edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    ADDR_TOP   = 2'd0,
    ADDR_CMP   = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_FORCE = 2'd3
  } addr_e;

  typedef struct packed {
    logic       inv_en;
    logic       true_en;
    logic       pwm;
    logic [1:0] omode;
    logic [2:0] clksel;
  } ctrl_t;

  localparam logic [1:0] OM_PWM  = 2'b01;
  localparam logic [1:0] OM_CLR  = 2'b10;
  localparam logic [1:0] OM_SET  = 2'b11;
endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clksel,
  input  logic       restart,
  output logic       tick
);
  localparam int NSTEP = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             run;

  assign run = (clksel != 3'd0);

  always_comb begin
    lim = '0;
    for (int i = 0; i < NSTEP; i++) begin
      if (int'(clksel) == i + 1 || (i == NSTEP - 1 && int'(clksel) > NSTEP))
        lim = DIV_W'((1 << i) - 1);
    end
  end

  assign tick = run && (div_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                    div_q <= '0;
    else if (!run || restart || tick) div_q <= '0;
    else                           div_q <= div_q + 1'b1;
  end

  // R1
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && lim != '0) |=> !tick);
  // R2
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel == 3'd0) |=> (div_q == '0));
endmodule

// File: rtl/cpwm_count.sv
module cpwm_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwm,
  input  logic             wr_top,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wval,
  output logic             set_ev,
  output logic             clr_ev
);
  logic [CNT_W-1:0] cnt_q, top_q, cmp_act_q, cmp_buf_q, cnt_inc;
  logic             at_top;

  assign at_top  = (cnt_q == top_q);
  assign cnt_inc = cnt_q + 1'b1;
  assign set_ev  = tick && at_top;
  assign clr_ev  = tick && !at_top && (cnt_inc == cmp_act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      top_q     <= '0;
      cmp_act_q <= '0;
      cmp_buf_q <= '0;
    end else begin
      if (wr_top) begin
        top_q <= wval;
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= at_top ? '0 : cnt_inc;
      end
      if (wr_cmp) cmp_buf_q <= wval;
      if (set_ev) cmp_act_q <= cmp_buf_q;
      if (wr_cmp && !pwm) cmp_act_q <= wval;
    end
  end

  // R1
  cnt_le_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_q);
  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !wr_top) |=> (cnt_q == '0));
  // R2
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_top) |=> $stable(cnt_q));
  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !set_ev) |=> $stable(cmp_act_q));
  // R5
  cmp_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && !pwm) |=> (cmp_act_q == $past(wval)));
endmodule

// File: rtl/cpwm_wave.sv
module cpwm_wave
  import cpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm,
  input  logic [1:0] omode,
  input  logic       force_stb,
  input  logic       set_ev,
  input  logic       clr_ev,
  input  logic       true_en,
  input  logic       inv_en,
  output logic       pin_true,
  output logic       pin_inv
);
  logic ff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else if (pwm) begin
      if (omode == OM_PWM) begin
        if (set_ev)      ff_q <= 1'b1;
        else if (clr_ev) ff_q <= 1'b0;
      end
    end else if (force_stb) begin
      if (omode == OM_CLR)      ff_q <= 1'b0;
      else if (omode == OM_SET) ff_q <= 1'b1;
    end
  end

  assign pin_true = true_en & ff_q;
  assign pin_inv  = inv_en & ~ff_q;

  // R6
  force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && force_stb && !set_ev && !clr_ev) |=> $stable(ff_q));
  // R7
  ff_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && !force_stb) |=> $stable(ff_q));
  // R3
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && omode == OM_PWM && set_ev) |=> ff_q);
  // R8
  true_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !true_en |-> !pin_true);
  // R8
  inv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en |-> !pin_inv);
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pin_true,
  output logic       pin_inv
);
  ctrl_t ctrl_q;
  logic  wr_top, wr_cmp, force_stb, tick, set_ev, clr_ev;

  assign wr_top    = wr_en && (wr_addr == ADDR_TOP);
  assign wr_cmp    = wr_en && (wr_addr == ADDR_CMP);
  assign force_stb = wr_en && (wr_addr == ADDR_FORCE) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                                 ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL)     ctrl_q <= ctrl_t'(wr_data);
  end

  cpwm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clksel(ctrl_q.clksel),
    .restart(wr_top), .tick(tick)
  );

  cpwm_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(ctrl_q.pwm),
    .wr_top(wr_top), .wr_cmp(wr_cmp), .wval(CNT_W'(wr_data)),
    .set_ev(set_ev), .clr_ev(clr_ev)
  );

  cpwm_wave u_wave (
    .clk(clk), .rst_n(rst_n), .pwm(ctrl_q.pwm), .omode(ctrl_q.omode),
    .force_stb(force_stb), .set_ev(set_ev), .clr_ev(clr_ev),
    .true_en(ctrl_q.true_en), .inv_en(ctrl_q.inv_en),
    .pin_true(pin_true), .pin_inv(pin_inv)
  );

  // R8
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.true_en && ctrl_q.inv_en) |-> (pin_true != pin_inv));
endmodule

// File: tb/sim_cpwm_channel.sv
`timescale 1ns/1ps
module sim_cpwm_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pin_true, pin_inv;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  cpwm_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_true(pin_true), .pin_inv(pin_inv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts the current high run then the following low run, in cycles.
  task automatic measure(output int h, output int l, output int badc);
    h = 0; l = 0; badc = 0;
    while (pin_true && h < 4000) begin
      h++; if (pin_inv == pin_true) badc++;
      @(negedge clk);
    end
    while (!pin_true && l < 4000) begin
      l++; if (pin_inv == pin_true) badc++;
      @(negedge clk);
    end
  endtask

  // Preset-high start: normal mode stopped, top, compare, force set, PWM on.
  task automatic start(input int top, input int cmp, input int sel);
    wr(2'd2, 8'hD8);
    wr(2'd0, 8'(top));
    wr(2'd1, 8'(cmp));
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hE8 | 8'(sel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int h, l, b, ratio, minrun;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(pin_true == 1'b0, "R10 pin_true after reset", pin_true, 0);
    chk(pin_inv == 1'b0, "R10 pin_inv after reset", pin_inv, 0);

    // R6 force set/clear in normal mode, R8 pins visible
    wr(2'd2, 8'hD8); wr(2'd3, 8'h01);
    chk(pin_true == 1'b1, "R6 force set", pin_true, 1);
    chk(pin_inv == 1'b0, "R8 inverted pin is complement", pin_inv, 0);
    wr(2'd2, 8'hC0); wr(2'd3, 8'h01);
    chk(pin_true == 1'b1, "R6 mode 00 force no effect", pin_true, 1);
    wr(2'd2, 8'hD0); wr(2'd3, 8'h01);
    chk(pin_true == 1'b0, "R6 force clear", pin_true, 0);
    wr(2'd2, 8'hD8); wr(2'd3, 8'h00);
    chk(pin_true == 1'b0, "R6 strobe without bit0 no effect", pin_true, 0);

    // R8 gating
    wr(2'd2, 8'h90);
    chk(pin_true == 1'b0 && pin_inv == 1'b1, "R8 only inverted pin enabled", {pin_true, pin_inv}, 1);
    wr(2'd2, 8'h58); wr(2'd3, 8'h01);
    chk(pin_true == 1'b1 && pin_inv == 1'b0, "R8 only true pin enabled", {pin_true, pin_inv}, 2);
    wr(2'd2, 8'h18);
    chk(pin_true == 1'b0 && pin_inv == 1'b0, "R8 both pins disabled", {pin_true, pin_inv}, 0);

    // R6 force ignored in PWM mode (mode 10 would clear outside PWM)
    wr(2'd2, 8'hF0); wr(2'd3, 8'h01);
    chk(pin_true == 1'b1, "R6 force ignored in PWM mode", pin_true, 1);

    // R7 / R2 retention across mode change and stopped clock
    wr(2'd2, 8'hD0); wr(2'd3, 8'h01);
    wr(2'd0, 8'd3); wr(2'd1, 8'd1);
    wr(2'd2, 8'hE8);
    b = 0;
    for (int i = 0; i < 30; i++) begin
      if (pin_true != 1'b0 || pin_inv != 1'b1) b++;
      @(negedge clk);
    end
    chk(b == 0, "R7 R2 level held while stopped in PWM", b, 0);

    // Sweep: top 7, every compare 1..7, divide by 1 and 2 (R1 R3 R5)
    for (int s = 1; s <= 2; s++) begin
      ratio = 1 << (s - 1);
      for (int c = 1; c <= 7; c++) begin
        start(7, c, s);
        measure(h, l, b);
        chk(h == c * ratio, "R5 R3 first high phase", h, c * ratio);
        chk(l == (8 - c) * ratio, "R3 first low phase", l, (8 - c) * ratio);
        chk(b == 0, "R8 complement during sweep", b, 0);
        measure(h, l, b);
        chk(h + l == 8 * ratio, "R1 period is top+1 ticks", h + l, 8 * ratio);
      end
    end

    // R2 divide by 8 and clamp of select 6
    start(7, 2, 4);
    measure(h, l, b);
    chk(h == 16 && l == 48, "R2 divide by 8", h * 1000 + l, 16048);
    start(7, 2, 6);
    measure(h, l, b);
    chk(h == 16 && l == 48, "R2 select 6 clamps to 8", h * 1000 + l, 16048);

    // R3 compare 0 keeps output high
    start(7, 0, 1);
    b = 0;
    for (int i = 0; i < 40; i++) begin
      if (!pin_true) b++;
      @(negedge clk);
    end
    chk(b == 0, "R3 compare zero stays high", b, 0);

    // R4 buffered compare write mid-period
    start(7, 3, 1);
    measure(h, l, b);
    chk(h == 3 && l == 5, "R4 initial period", h * 1000 + l, 3005);
    wr(2'd1, 8'd5);
    measure(h, l, b);
    chk(h == 1 && l == 5, "R4 current period keeps old compare", h * 1000 + l, 1005);
    measure(h, l, b);
    chk(h == 5 && l == 3, "R4 next period uses new compare", h * 1000 + l, 5003);

    // R9 preset-then-start, top 35, compare 17, divide by 4
    start(35, 17, 3);
    minrun = 100000;
    for (int p = 0; p < 3; p++) begin
      measure(h, l, b);
      chk(h == 68, "R9 high phase", h, 68);
      chk(l == 76, "R9 low phase", l, 76);
      chk(b == 0, "R9 complementary pins", b, 0);
      if (h < minrun) minrun = h;
      if (l < minrun) minrun = l;
    end
    chk(minrun >= 4, "R9 no phase shorter than one tick", minrun, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule